// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits on the address path between one bus master and a set of target ports. It cuts the 32-bit master address space into sixteen 256 MB windows, using the top four address bits as the window number. Every window holds a 4-bit target code and a 4-bit replacement window number. An accepted request goes out on the port named by the code, with the top nibble of its address swapped for the replacement number and the lower 28 bits passed through unchanged. A window whose code is zero, or whose code names no existing port, answers with a decode-error handshake and reaches no port.

Software builds the map through a small 32-bit register write port. The writes land in a shadow copy. A write of 1 to the commit register then loads the whole shadow copy into the live map in one cycle. Reads return the shadow copy, so the next map can be staged and checked while the current map is still routing traffic.

A three-state controller moves each request through the block, one at a time. In IDLE the master is ready. The accept-mapped transition goes from IDLE to FWD, and the accept-unmapped transition goes from IDLE to ERR. In FWD the selected port's valid is held until that port is ready, then the port-done transition returns to IDLE. In ERR the error valid is held until the error ready arrives, then the error-done transition returns to IDLE. The decoded port and address are captured on acceptance.

Top module: `aperture_remap`

## Requirements
- R1: The window number of a request is m_addr[31:28]; window w uses the code and replacement number held in the nibble at bits [4(w mod 8)+3 : 4(w mod 8)] of its register.
- R2: A forwarded request drives s_addr = {replacement nibble, m_addr[27:0]}.
- R3: Code c in the range 1 to 7 routes the request to port c-1, so s_valid = 1 << (c-1); several windows may share one port with different replacement numbers.
- R4: Code 0, or a code of 8 to 15, raises err_valid with s_valid all zero, and forwards nothing.
- R5: Register byte offsets: 0x00 holds the codes for windows 0-7, 0x04 the codes for windows 8-15, 0x08 the replacement numbers for windows 0-7, and 0x0C the replacement numbers for windows 8-15; 0x10 is the commit register.
- R6: Writes to 0x00-0x0C have no effect on routing until a write to 0x10 with bit 0 set; that write loads all four shadow registers into the live map at once.
- R7: After reset both the shadow map and the live map are zero, so every request gets the error response and every register reads 0.
- R8: cfg_rdata returns the shadow value at 0x00-0x0C, and reads 0 at 0x10 and at every other offset.
- R9: A request already accepted keeps its captured port and address even if a commit happens while it waits; requests accepted after the commit cycle use the new map.
- R10: One request is handled at a time: m_ready is high only in IDLE; s_valid and s_addr stay constant until the selected port's s_ready; err_valid stays high until err_ready; at most one of the s_valid bits and err_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register byte address (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Master request accepted |
| m_addr | input | 32 | Master request address |
| s_valid | output | 7 | Per-port request valid, bit p for code p+1 |
| s_ready | input | 7 | Per-port ready |
| s_addr | output | 32 | Remapped address shared by all ports |
| err_valid | output | 1 | Decode-error response valid |
| err_ready | input | 1 | Decode-error response accepted |

## Verification
The assertions assume that a port's s_ready is only meaningful while that port's s_valid is high. They also assume that err_ready is sampled only in the error state, and that register accesses use word-aligned offsets. The stimulus changes every input at the falling edge. It raises s_ready and err_ready only after the held outputs have been checked, and it drops them again after one cycle. It issues a commit during a request held in FWD, so the capture of the decoded port and address is exercised while the live map changes underneath it.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int ADDR_W     = 32;
    localparam int WIN_BITS   = 4;
    localparam int NUM_WIN    = 1 << WIN_BITS;
    localparam int FIELD_W    = 4;
    localparam int WORD_W     = 32;
    localparam int PER_WORD   = WORD_W / FIELD_W;
    localparam int MAP_WORDS  = NUM_WIN / PER_WORD;
    localparam int MAP_W      = NUM_WIN * FIELD_W;
    localparam int LOW_W      = ADDR_W - WIN_BITS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_ERR  = 2'd2
    } remap_state_e;
endpackage

// File: rtl/remap_regs.sv
module remap_regs
    import remap_pkg::*;
#(
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic [MAP_W-1:0]  live_code,
    output logic [MAP_W-1:0]  live_win
);
    localparam int IDX_W     = CFG_AW - 2;
    localparam int COMMIT_IX = 2 * MAP_WORDS;

    logic [IDX_W-1:0] widx;
    logic [MAP_W-1:0] shd_code;
    logic [MAP_W-1:0] shd_win;
    logic             commit;

    assign widx   = cfg_addr[CFG_AW-1:2];
    assign commit = cfg_we && (widx == IDX_W'(COMMIT_IX)) && cfg_wdata[0];

    // R5: code words first, replacement words after them, commit last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_code <= '0;
            shd_win  <= '0;
        end else if (cfg_we) begin
            for (int w = 0; w < MAP_WORDS; w++) begin
                if (widx == IDX_W'(w))
                    shd_code[w*WORD_W +: WORD_W] <= cfg_wdata;
                if (widx == IDX_W'(w + MAP_WORDS))
                    shd_win[w*WORD_W +: WORD_W] <= cfg_wdata;
            end
        end
    end

    // R6: live map changes only on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_code <= '0;
            live_win  <= '0;
        end else if (commit) begin
            live_code <= shd_code;
            live_win  <= shd_win;
        end
    end

    // R8: shadow read-back, zero elsewhere
    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < MAP_WORDS; w++) begin
            if (widx == IDX_W'(w))
                cfg_rdata = shd_code[w*WORD_W +: WORD_W];
            if (widx == IDX_W'(w + MAP_WORDS))
                cfg_rdata = shd_win[w*WORD_W +: WORD_W];
        end
    end

    a_r6_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(live_code) && $stable(live_win)));

    a_r6_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_code == $past(shd_code) && live_win == $past(shd_win)));
endmodule

// File: rtl/remap_decode.sv
module remap_decode
    import remap_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic [MAP_W-1:0]  live_code,
    input  logic [MAP_W-1:0]  live_win,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_hit,
    output logic [PORT_W-1:0] dec_port,
    output logic [ADDR_W-1:0] dec_addr
);
    localparam logic [FIELD_W-1:0] TOP_CODE = FIELD_W'(NUM_PORTS);

    logic [WIN_BITS-1:0] win;
    logic [FIELD_W-1:0]  code_tab [NUM_WIN];
    logic [FIELD_W-1:0]  win_tab  [NUM_WIN];
    logic [FIELD_W-1:0]  code;

    // R1: split the flat maps into one nibble per window
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign code_tab[g] = live_code[g*FIELD_W +: FIELD_W];
        assign win_tab[g]  = live_win[g*FIELD_W +: FIELD_W];
    end

    assign win      = req_addr[ADDR_W-1 -: WIN_BITS];
    assign code     = code_tab[win];
    // R3 / R4: legal codes are 1..NUM_PORTS
    assign dec_hit  = (code != '0) && (code <= TOP_CODE);
    assign dec_port = PORT_W'(code - FIELD_W'(1));
    // R2: swap the window nibble
    assign dec_addr = {win_tab[win], req_addr[LOW_W-1:0]};
endmodule

// File: rtl/remap_fsm.sv
module remap_fsm
    import remap_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 m_valid,
    output logic                 m_ready,
    input  logic                 dec_hit,
    input  logic [PORT_W-1:0]    dec_port,
    input  logic [ADDR_W-1:0]    dec_addr,
    output logic [NUM_PORTS-1:0] s_valid,
    input  logic [NUM_PORTS-1:0] s_ready,
    output logic [ADDR_W-1:0]    s_addr,
    output logic                 err_valid,
    input  logic                 err_ready
);
    remap_state_e      state, state_nx;
    logic [PORT_W-1:0] tx_port;
    logic [ADDR_W-1:0] tx_addr;
    logic              accept;

    assign accept = m_valid && (state == ST_IDLE);

    // state register and R9 capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tx_port <= '0;
            tx_addr <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                tx_port <= dec_port;
                tx_addr <= dec_addr;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        m_ready   = 1'b0;
        s_valid   = '0;
        err_valid = 1'b0;
        s_addr    = tx_addr;
        unique case (state)
            ST_IDLE: begin
                m_ready = 1'b1;
                if (m_valid)
                    state_nx = dec_hit ? ST_FWD : ST_ERR;
            end
            ST_FWD: begin
                s_valid[tx_port] = 1'b1;
                if (s_ready[tx_port])
                    state_nx = ST_IDLE;
            end
            ST_ERR: begin
                err_valid = 1'b1;
                if (err_ready)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_valid, err_valid}));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((|s_valid) || err_valid) |-> !m_ready);

    a_r10_fwd_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((|s_valid) && ((s_valid & s_ready) == '0)) |=>
            (s_valid == $past(s_valid) && $stable(s_addr)));

    a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_ready) |=> err_valid);
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import remap_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int CFG_AW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    input  logic                 m_valid,
    output logic                 m_ready,
    input  logic [ADDR_W-1:0]    m_addr,
    output logic [NUM_PORTS-1:0] s_valid,
    input  logic [NUM_PORTS-1:0] s_ready,
    output logic [ADDR_W-1:0]    s_addr,
    output logic                 err_valid,
    input  logic                 err_ready
);
    localparam int PORT_W = $clog2(NUM_PORTS);

    logic [MAP_W-1:0]  live_code;
    logic [MAP_W-1:0]  live_win;
    logic              dec_hit;
    logic [PORT_W-1:0] dec_port;
    logic [ADDR_W-1:0] dec_addr;

    remap_regs #(.CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .live_code (live_code),
        .live_win  (live_win)
    );

    remap_decode #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dec (
        .live_code (live_code),
        .live_win  (live_win),
        .req_addr  (m_addr),
        .dec_hit   (dec_hit),
        .dec_port  (dec_port),
        .dec_addr  (dec_addr)
    );

    remap_fsm #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_valid   (m_valid),
        .m_ready   (m_ready),
        .dec_hit   (dec_hit),
        .dec_port  (dec_port),
        .dec_addr  (dec_addr),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_addr    (s_addr),
        .err_valid (err_valid),
        .err_ready (err_ready)
    );

    a_r4_unmapped_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !dec_hit) |=> (err_valid && s_valid == '0));

    a_r2_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && dec_hit) |=>
            (s_addr[LOW_W-1:0] == $past(m_addr[LOW_W-1:0])));
endmodule

// File: tb/aperture_remap_test.sv
`timescale 1ns/1ps
module aperture_remap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        m_valid = 1'b0;
    logic        m_ready;
    logic [31:0] m_addr = '0;
    logic [6:0]  s_valid;
    logic [6:0]  s_ready = '0;
    logic [31:0] s_addr;
    logic        err_valid;
    logic        err_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    aperture_remap uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_valid(m_valid),
        .m_ready(m_ready), .m_addr(m_addr), .s_valid(s_valid),
        .s_ready(s_ready), .s_addr(s_addr), .err_valid(err_valid),
        .err_ready(err_ready)
    );

    // {request address, expected code (0 = error), expected s_addr}
    localparam logic [67:0] VEC [12] = '{
        {32'h0123_4567, 4'd1, 32'h0123_4567},
        {32'h1ABC_DEF0, 4'd1, 32'h1ABC_DEF0},
        {32'h2000_0004, 4'd2, 32'h0000_0004},
        {32'h3FFF_FFFF, 4'd0, 32'h0},
        {32'h5000_0000, 4'd0, 32'h0},
        {32'h8000_0010, 4'd6, 32'h0000_0010},
        {32'h9123_0000, 4'd6, 32'h1123_0000},
        {32'hB0FF_FFFF, 4'd6, 32'h30FF_FFFF},
        {32'hC000_0000, 4'd0, 32'h0},
        {32'hD555_0000, 4'd3, 32'hD555_0000},
        {32'hE000_1000, 4'd3, 32'hE000_1000},
        {32'hF000_0008, 4'd7, 32'h0000_0008}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    // handshake, then check the held outputs one cycle later
    task automatic issue(input logic [31:0] a);
        @(negedge clk);
        m_valid = 1'b1; m_addr = a;
        @(negedge clk);
        m_valid = 1'b0;
    endtask

    task automatic expect_out(input logic [3:0] code, input logic [31:0] exp_addr,
                              input string req);
        if (code == 4'd0) begin
            check(err_valid && s_valid == '0, req, {24'b0, s_valid, err_valid}, 32'h1);
        end else begin
            check(s_valid == 7'(1 << (code - 1)) && !err_valid, req,
                  {25'b0, s_valid}, 32'(1 << (code - 1)));
            check(s_addr == exp_addr, req, s_addr, exp_addr);
        end
    endtask

    task automatic release_out();
        s_ready = '1; err_ready = 1'b1;
        @(negedge clk);
        s_ready = '0; err_ready = 1'b0;
        check(m_ready && s_valid == '0 && !err_valid, "R10",
              {24'b0, s_valid, m_ready}, 32'h1);
    endtask

    task automatic access(input logic [31:0] a, input logic [3:0] code,
                          input logic [31:0] exp_addr, input string req);
        issue(a);
        expect_out(code, exp_addr, req);
        release_out();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        check(m_ready && s_valid == '0 && !err_valid, "R7", {24'b0, s_valid, m_ready}, 32'h1);
        for (int o = 0; o < 5; o++) cfg_check(8'(o * 4), 32'h0, "R7");
        access(32'h8000_0000, 4'd0, 32'h0, "R7");
        access(32'h0000_0000, 4'd0, 32'h0, "R7");

        // R5: program shadow map
        cfg_write(8'h00, 32'h0000_9211);
        cfg_write(8'h04, 32'h7330_6666);
        cfg_write(8'h08, 32'h0000_0010);
        cfg_write(8'h0C, 32'h0ED0_3210);
        // R6: not live before commit
        access(32'h2000_0004, 4'd0, 32'h0, "R6");
        // R8: shadow read-back and undefined offsets
        cfg_check(8'h00, 32'h0000_9211, "R8");
        cfg_check(8'h04, 32'h7330_6666, "R8");
        cfg_check(8'h08, 32'h0000_0010, "R8");
        cfg_check(8'h0C, 32'h0ED0_3210, "R8");
        cfg_write(8'h10, 32'h0000_0000);   // bit 0 clear: no commit (R6)
        access(32'h2000_0004, 4'd0, 32'h0, "R6");
        cfg_write(8'h10, 32'h0000_0001);   // commit
        cfg_check(8'h10, 32'h0, "R8");
        cfg_check(8'h14, 32'h0, "R8");
        cfg_check(8'hFC, 32'h0, "R8");

        // R1 R2 R3 R4 via table
        for (int i = 0; i < 12; i++) begin
            access(VEC[i][67:36], VEC[i][35:32], VEC[i][31:0],
                   VEC[i][35:32] == 4'd0 ? "R4" : "R1/R2/R3");
        end

        // R9: commit while a request is held in FWD
        issue(32'hF000_0008);
        cfg_write(8'h04, 32'h2330_6666);
        cfg_write(8'h0C, 32'h5ED0_3210);
        cfg_write(8'h10, 32'h0000_0001);
        expect_out(4'd7, 32'h0000_0008, "R9");
        check(!m_ready, "R10", {31'b0, m_ready}, 32'h0);
        release_out();
        access(32'hF000_0008, 4'd2, 32'h5000_0008, "R9");

        // R10: error held until err_ready
        issue(32'hC000_0000);
        @(negedge clk);
        check(err_valid && !m_ready, "R10", {30'b0, err_valid, m_ready}, 32'h2);
        release_out();

        // R6: shadow cleared but live map kept
        cfg_write(8'h00, 32'h0);
        cfg_check(8'h00, 32'h0, "R8");
        access(32'h0123_4567, 4'd1, 32'h0123_4567, "R6");
        cfg_write(8'h10, 32'h1);
        access(32'h0123_4567, 4'd0, 32'h0, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule